// File: doc/BRIEF.md
# Dual-Output Interrupt Controller with Split-Word Register Port

This block gathers 51 interrupt lines into two processor-facing outputs: a normal interrupt request line and a fast interrupt request line. Each line has its own trigger behaviour. A line is either level-sensitive or edge-sensitive. An edge line reacts to one polarity of edge or to both. The polarity bit also decides whether a level line is active-high or active-low. A per-line raw status bit records the trigger. The enable mask gates the raw bit, and a route mask sends each enabled line to one of the two outputs.

Software reaches the controller through a 32-bit word port. Every 51-bit logical register is split into a low word (bits 31:0) and a high word (bits 50:32). Enables and edge status have separate set-style and clear-style addresses, so software never has to read, modify and write them. The trigger configuration is fixed when the block is built. The only exception is the polarity of the four topmost lines, which software can change. The interrupt lines are assumed to be already synchronous to `clk`.

Top module: `dual_line_intc`

## Requirements
- R1: After reset, the enable, route and raw status registers are all zero and both outputs are low. The sensitivity register reads 0x1F07FFF8FFFF (1 = level), the both-edge register reads 0xF800070000, and the polarity register reads 0x5F07FFF8FFFF.
- R2: Address bit 2 picks the word: 0 selects the low word (bits 31:0) and 1 selects the high word (bits 50:32). A high-word read returns zeros in bits 31:19.
- R3: Reads return 0 and writes have no effect for byte addresses below 0x80, for addresses with bits 1:0 non-zero, for unmapped offsets, and for the clear-only offsets 0xA8/0xAC and 0xD8/0xDC.
- R4: Offset 0x80 reads raw AND NOT route AND enable. Offset 0x88 reads raw AND route AND enable. Offset 0x90 reads raw. Offset 0xE0 reads raw AND NOT sensitivity.
- R5: Writing ones to 0xA0 (low) or 0xA4 (high) sets the matching enable bits. Writing ones to 0xA8/0xAC clears them. Zero bits leave the enables unchanged. Offset 0xA0/0xA4 reads back the enables.
- R6: A write to 0x98 (low) or 0x9C (high) replaces only that word of the route mask and keeps the other word. A route bit of 1 sends the line to the fast output.
- R7: A level line's raw bit takes its input value one clock later, inverted when the line's polarity bit is 0.
- R8: An edge line with its both-edge bit set raises raw on any change of input. Otherwise it raises raw on a rising edge when polarity is 1 and on a falling edge when polarity is 0. The edge is taken against the level sampled on the previous clock, and raw stays set after the input returns.
- R9: Writing ones to 0xD8/0xDC clears raw bits of edge lines only. If an edge and a clear of the same line fall in the same clock, the bit stays set.
- R10: Only polarity bits 50:47 are writable, through bits 18:15 of a write to 0xD4. A write to 0xD0 is ignored.
- R11: Writes to the status, sensitivity (0xC0/0xC4) and both-edge (0xC8/0xCC) offsets change nothing.
- R12: `irqOut` is the OR of raw AND enable AND NOT route, and `fiqOut` is the OR of raw AND enable AND route. Both follow the registers in the same cycle they update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 51 | Interrupt lines, synchronous to clk |
| wrEn | input | 1 | Write strobe for one word |
| rdEn | input | 1 | Read strobe; rdData is 0 when low |
| addr | input | 8 | Byte address of the word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from addr and state |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The bench goes after a clear and an edge on the same line in the same clock. A design that let the clear win would lose an interrupt that arrives while software acknowledges the previous one. It aims clears at level lines, which a design that skipped the sensitivity mask would wrongly drop. It writes one word of the route mask and reads the other, which a full-width write would zero. It also sends polarity writes to the low word, a falling edge into a line that reacts only to falling edges, and a toggle into a both-edge line. Each of these exposes a decoder that mixes up words or edge kinds as a wrong raw bit or a wrong output.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int NSRC = 51;

  // Build-time trigger configuration (bit i = line i)
  localparam logic [63:0] SENSE_DEF  = 64'h0000_1F07_FFF8_FFFF; // 1 = level
  localparam logic [63:0] DUAL_DEF   = 64'h0000_00F8_0007_0000; // 1 = both edges
  localparam logic [63:0] EVT_DEF    = 64'h0000_5F07_FFF8_FFFF; // 1 = high / rising
  localparam logic [63:0] EVT_WR_DEF = 64'h0007_8000_0000_0000; // writable polarity bits

  // Register offsets (low word; +4 = high word)
  localparam logic [7:0] OFF_WINDOW   = 8'h80;
  localparam logic [7:0] OFF_IRQ_STAT = 8'h80;
  localparam logic [7:0] OFF_FIQ_STAT = 8'h88;
  localparam logic [7:0] OFF_RAW      = 8'h90;
  localparam logic [7:0] OFF_ROUTE    = 8'h98;
  localparam logic [7:0] OFF_EN_SET   = 8'hA0;
  localparam logic [7:0] OFF_EN_CLR   = 8'hA8;
  localparam logic [7:0] OFF_SENSE    = 8'hC0;
  localparam logic [7:0] OFF_DUAL     = 8'hC8;
  localparam logic [7:0] OFF_POL      = 8'hD0;
  localparam logic [7:0] OFF_EDGE_CLR = 8'hD8;
  localparam logic [7:0] OFF_EDGE     = 8'hE0;

  typedef enum logic [3:0] {
    RD_NONE, RD_IRQ, RD_FIQ, RD_RAW, RD_ROUTE, RD_EN,
    RD_SENSE, RD_DUAL, RD_POL, RD_EDGE
  } rdSel_e;

  typedef struct packed {
    logic   hiHalf;
    logic   routeWr;
    logic   enSet;
    logic   enClr;
    logic   edgeClr;
    logic   polWr;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/intc_src_cell.sv
// One interrupt line: previous-level store, edge detect and raw status bit.
module intc_src_cell #(
  parameter bit IS_LEVEL = 1'b0,
  parameter bit IS_DUAL  = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic srcIn,
  input  logic polarity,
  input  logic clrReq,
  output logic rawQ
);

  logic prevQ;
  logic rise;
  logic fall;
  logic hit;
  logic rawD;

  always_comb begin
    rise = srcIn & ~prevQ;
    fall = ~srcIn & prevQ;
    if (IS_DUAL) hit = rise | fall;
    else         hit = polarity ? rise : fall;
    if (IS_LEVEL) rawD = polarity ? srcIn : ~srcIn;
    else          rawD = hit | (rawQ & ~clrReq);  // a fresh edge beats the clear
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ <= 1'b0;
      rawQ  <= 1'b0;
    end else begin
      prevQ <= srcIn;
      rawQ  <= rawD;
    end
  end

endmodule

// File: rtl/intc_ctrl.sv
// Address decode: turns a word access into a strobe bundle for the datapath.
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(OFF_WINDOW);

  logic              aligned;
  logic              inWin;
  logic              doWr;
  logic              doRd;
  logic [ADDR_W-1:0] regIdx;

  assign aligned = (addr[1:0] == 2'b00);
  assign inWin   = (addr >= WIN_BASE);
  assign doWr    = wrEn && aligned && inWin;
  assign doRd    = rdEn && aligned && inWin;
  assign regIdx  = {addr[ADDR_W-1:3], 3'b000};

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_NONE;
    strobe.hiHalf = addr[2];
    case (regIdx)
      ADDR_W'(OFF_IRQ_STAT): if (doRd) strobe.rdSel = RD_IRQ;
      ADDR_W'(OFF_FIQ_STAT): if (doRd) strobe.rdSel = RD_FIQ;
      ADDR_W'(OFF_RAW):      if (doRd) strobe.rdSel = RD_RAW;
      ADDR_W'(OFF_ROUTE): begin
        strobe.routeWr = doWr;
        if (doRd) strobe.rdSel = RD_ROUTE;
      end
      ADDR_W'(OFF_EN_SET): begin
        strobe.enSet = doWr;
        if (doRd) strobe.rdSel = RD_EN;
      end
      ADDR_W'(OFF_EN_CLR):   strobe.enClr = doWr;
      ADDR_W'(OFF_SENSE):    if (doRd) strobe.rdSel = RD_SENSE;
      ADDR_W'(OFF_DUAL):     if (doRd) strobe.rdSel = RD_DUAL;
      ADDR_W'(OFF_POL): begin
        strobe.polWr = doWr && addr[2];
        if (doRd) strobe.rdSel = RD_POL;
      end
      ADDR_W'(OFF_EDGE_CLR): strobe.edgeClr = doWr;
      ADDR_W'(OFF_EDGE):     if (doRd) strobe.rdSel = RD_EDGE;
      default: ;
    endcase
  end

endmodule

// File: rtl/intc_core.sv
// Datapath: mask registers, per-line cells, output OR trees, read mux.
module intc_core
  import intc_pkg::*;
#(
  parameter int          NUM_SRC     = NSRC,
  parameter logic [63:0] SENSE_RST   = SENSE_DEF,
  parameter logic [63:0] DUAL_RST    = DUAL_DEF,
  parameter logic [63:0] EVT_RST     = EVT_DEF,
  parameter logic [63:0] EVT_WR_MASK = EVT_WR_DEF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  ctrlStrobe_t        strobe,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdWord,
  output logic               irqOut,
  output logic               fiqOut
);

  localparam int HI_W = NUM_SRC - 32;
  localparam logic [NUM_SRC-1:0] SENSE    = SENSE_RST[NUM_SRC-1:0];
  localparam logic [NUM_SRC-1:0] DUAL     = DUAL_RST[NUM_SRC-1:0];
  localparam logic [NUM_SRC-1:0] POL_INIT = EVT_RST[NUM_SRC-1:0];
  localparam logic [NUM_SRC-1:0] POL_WMSK = EVT_WR_MASK[NUM_SRC-1:0];

  logic [NUM_SRC-1:0] rawVec;
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] routeQ;
  logic [NUM_SRC-1:0] polQ;
  logic [NUM_SRC-1:0] wide;
  logic [NUM_SRC-1:0] halfMask;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] activeVec;
  logic [NUM_SRC-1:0] pickWide;

  // Place the written word at its half of the logical register
  assign wide     = strobe.hiHalf ? {wrData[HI_W-1:0], 32'h0}
                                  : {{HI_W{1'b0}}, wrData};
  assign halfMask = strobe.hiHalf ? {{HI_W{1'b1}}, 32'h0}
                                  : {{HI_W{1'b0}}, 32'hFFFF_FFFF};
  assign clrVec   = strobe.edgeClr ? (wide & ~SENSE) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ    <= '0;
      routeQ <= '0;
      polQ   <= POL_INIT;
    end else begin
      if (strobe.enSet)   enQ    <= enQ | wide;
      if (strobe.enClr)   enQ    <= enQ & ~wide;
      if (strobe.routeWr) routeQ <= (routeQ & ~halfMask) | wide;
      if (strobe.polWr)   polQ   <= (polQ & ~POL_WMSK) | (wide & POL_WMSK);
    end
  end

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_line
    intc_src_cell #(
      .IS_LEVEL(SENSE[gi]),
      .IS_DUAL (DUAL[gi])
    ) u_cell (
      .clk     (clk),
      .rstN    (rstN),
      .srcIn   (srcIn[gi]),
      .polarity(polQ[gi]),
      .clrReq  (clrVec[gi]),
      .rawQ    (rawVec[gi])
    );
  end

  assign activeVec = rawVec & enQ;
  assign irqOut    = |(activeVec & ~routeQ);
  assign fiqOut    = |(activeVec & routeQ);

  always_comb begin
    case (strobe.rdSel)
      RD_IRQ:   pickWide = activeVec & ~routeQ;
      RD_FIQ:   pickWide = activeVec & routeQ;
      RD_RAW:   pickWide = rawVec;
      RD_ROUTE: pickWide = routeQ;
      RD_EN:    pickWide = enQ;
      RD_SENSE: pickWide = SENSE;
      RD_DUAL:  pickWide = DUAL;
      RD_POL:   pickWide = polQ;
      RD_EDGE:  pickWide = rawVec & ~SENSE;
      default:  pickWide = '0;
    endcase
  end

  assign rdWord = strobe.hiHalf ? {{(32-HI_W){1'b0}}, pickWide[NUM_SRC-1:32]}
                                : pickWide[31:0];

endmodule

// File: rtl/dual_line_intc.sv
module dual_line_intc
  import intc_pkg::*;
#(
  parameter int          NUM_SRC     = NSRC,
  parameter int          ADDR_W      = 8,
  parameter logic [63:0] SENSE_RST   = SENSE_DEF,
  parameter logic [63:0] DUAL_RST    = DUAL_DEF,
  parameter logic [63:0] EVT_RST     = EVT_DEF,
  parameter logic [63:0] EVT_WR_MASK = EVT_WR_DEF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               irqOut,
  output logic               fiqOut
);

  ctrlStrobe_t strobe;

  intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .strobe(strobe)
  );

  intc_core #(
    .NUM_SRC    (NUM_SRC),
    .SENSE_RST  (SENSE_RST),
    .DUAL_RST   (DUAL_RST),
    .EVT_RST    (EVT_RST),
    .EVT_WR_MASK(EVT_WR_MASK)
  ) u_core (
    .clk   (clk),
    .rstN  (rstN),
    .srcIn (srcIn),
    .strobe(strobe),
    .wrData(wrData),
    .rdWord(rdData),
    .irqOut(irqOut),
    .fiqOut(fiqOut)
  );

endmodule

// File: rtl/dual_line_intc_chk.sv
module dual_line_intc_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = NSRC,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               wrEn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [31:0]        rdData,
  input logic               irqOut,
  input logic               fiqOut
);

  localparam int HI_W = NUM_SRC - 32;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irqOut && !fiqOut));

  // R2
  hi_pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[2]) |-> (rdData[31:HI_W] == '0));

  // R3
  legacy_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr < ADDR_W'(OFF_WINDOW))) |-> (rdData == 32'h0));

  // R3
  clear_only_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && ({addr[ADDR_W-1:3], 3'b000} == ADDR_W'(OFF_EN_CLR) ||
              {addr[ADDR_W-1:3], 3'b000} == ADDR_W'(OFF_EDGE_CLR)))
    |-> (rdData == 32'h0));

  // R11
  sense_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(OFF_SENSE)) |-> (rdData == SENSE_DEF[31:0]));

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && $stable(srcIn)) |=> ($stable(irqOut) && $stable(fiqOut)));

endmodule

bind dual_line_intc dual_line_intc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .srcIn (srcIn),
  .wrEn  (wrEn),
  .rdEn  (rdEn),
  .addr  (addr),
  .rdData(rdData),
  .irqOut(irqOut),
  .fiqOut(fiqOut)
);

// File: tb/test_dual_line_intc.sv
module test_dual_line_intc;

  localparam logic [50:0] M_SENSE = 51'h1F07FFF8FFFF;
  localparam logic [50:0] M_DUAL  = 51'h00F800070000;
  localparam logic [50:0] M_POL0  = 51'h5F07FFF8FFFF;
  localparam logic [50:0] M_POLW  = 51'h7800000000000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [50:0] srcIn = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  logic        fiqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_line_intc i_dual_line_intc (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // Behavioural reference state
  logic [50:0] mRaw, mEn, mSel, mPol, mPrev;
  logic [50:0] mWide, mClr, mNext;
  bit          mHit;

  always @(posedge clk) begin
    if (!rstN) begin
      mRaw = '0; mEn = '0; mSel = '0; mPol = M_POL0; mPrev = '0;
    end else begin
      mWide = addr[2] ? (51'(wrData[18:0]) << 32) : 51'(wrData);
      mClr  = '0;
      if (wrEn && addr[1:0] == 2'b00 && {addr[7:3], 3'b000} == 8'hD8)
        mClr = mWide & ~M_SENSE;
      for (int i = 0; i < 51; i++) begin
        if (M_SENSE[i]) begin
          mNext[i] = mPol[i] ? srcIn[i] : !srcIn[i];
        end else begin
          if (M_DUAL[i]) mHit = (srcIn[i] != mPrev[i]);
          else if (mPol[i]) mHit = srcIn[i] && !mPrev[i];
          else mHit = !srcIn[i] && mPrev[i];
          mNext[i] = mHit || (mRaw[i] && !mClr[i]);
        end
      end
      mPrev = srcIn;
      if (wrEn && addr[1:0] == 2'b00 && addr >= 8'h80) begin
        case ({addr[7:3], 3'b000})
          8'h98: if (addr[2]) mSel[50:32] = wrData[18:0]; else mSel[31:0] = wrData;
          8'hA0: mEn = mEn | mWide;
          8'hA8: mEn = mEn & ~mWide;
          8'hD0: if (addr[2]) mPol = (mPol & ~M_POLW) | (mWide & M_POLW);
          default: ;
        endcase
      end
      mRaw = mNext;
    end
  end

  function automatic logic [31:0] mread(logic [7:0] a);
    logic [50:0] v;
    if (a[1:0] != 2'b00 || a < 8'h80) return 32'h0;
    case ({a[7:3], 3'b000})
      8'h80: v = mRaw & ~mSel & mEn;
      8'h88: v = mRaw & mSel & mEn;
      8'h90: v = mRaw;
      8'h98: v = mSel;
      8'hA0: v = mEn;
      8'hC0: v = M_SENSE;
      8'hC8: v = M_DUAL;
      8'hD0: v = mPol;
      8'hE0: v = mRaw & ~M_SENSE;
      default: v = '0;
    endcase
    return a[2] ? {13'h0, v[50:32]} : v[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R12: outputs compared with the model on every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R12 irqOut", 32'(irqOut), 32'(|(mRaw & mEn & ~mSel)));
      check("R12 fiqOut", 32'(fiqOut), 32'(|(mRaw & mEn & mSel)));
    end
  end

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1;
    check(tag, rdData, mread(a));
    rdEn = 1'b0;
  endtask

  task automatic rdx(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1;
    check(tag, rdData, exp);
    rdEn = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic src(int i, logic v);
    @(negedge clk);
    srcIn[i] = v;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset values
    @(negedge clk);
    check("R1 irqOut reset", 32'(irqOut), 32'h0);
    rdx(8'hC0, 32'hFFF8FFFF, "R1 sense lo");
    rdx(8'hC4, 32'h00001F07, "R1 sense hi");
    rdx(8'hC8, 32'h00070000, "R1 dual lo");
    rdx(8'hCC, 32'h000000F8, "R1 dual hi");
    rdx(8'hD4, 32'h00005F07, "R1 pol hi");
    rdx(8'hA0, 32'h0, "R1 enable lo");
    rdx(8'h90, 32'h0, "R1 raw lo");
    // R3 legacy window, misaligned
    rdx(8'h00, 32'h0, "R3 legacy read");
    rdx(8'hC1, 32'h0, "R3 misaligned read");
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'hA1, 32'hFFFFFFFF);
    rdx(8'hA0, 32'h0, "R3 legacy/misaligned write ignored");
    // R5 enable set
    wr(8'hA0, 32'hFFFFFFFF);
    wr(8'hA4, 32'h0007FFFF);
    rdx(8'hA4, 32'h0007FFFF, "R5 enable hi set");
    rdx(8'hA8, 32'h0, "R3 clear-only read");
    // R7 level line 5
    src(5, 1'b1);
    rdx(8'h90, 32'h00000020, "R7 level follows");
    check("R12 irq from level", 32'(irqOut), 32'h1);
    rd(8'h80, "R4 irq status");
    // R6 route: low word then high word keeps low
    wr(8'h98, 32'h00000020);
    wr(8'h9C, 32'h00000001);
    rdx(8'h98, 32'h00000020, "R6 route lo kept");
    rdx(8'h9C, 32'h00000001, "R2 route hi");
    check("R6 fiq routed", 32'(fiqOut), 32'h1);
    rd(8'h88, "R4 fiq status");
    // R9 clear ignored on level line
    wr(8'hD8, 32'h00000020);
    rdx(8'h90, 32'h00000020, "R9 level not cleared");
    src(5, 1'b0);
    rdx(8'h90, 32'h0, "R7 level drops");
    // R8 dual edge line 16
    src(16, 1'b1);
    src(16, 1'b0);
    rdx(8'h90, 32'h00010000, "R8 dual edge latched");
    rd(8'hE0, "R4 edge status");
    wr(8'hD8, 32'h00010000);
    rdx(8'h90, 32'h0, "R9 edge cleared");
    // R8 falling-only line 45 (hi bit 13)
    src(45, 1'b1);
    rdx(8'h94, 32'h0, "R8 rise ignored on falling line");
    src(45, 1'b0);
    rdx(8'h94, 32'h00002000, "R8 falling edge");
    // R8 rising-only line 46 (hi bit 14)
    src(46, 1'b1);
    rdx(8'h94, 32'h00006000, "R8 rising edge");
    // R10 polarity writes
    wr(8'hD0, 32'h0);
    rdx(8'hD0, 32'hFFF8FFFF, "R10 low word pol write ignored");
    wr(8'hD4, 32'hFFFFFFFF);
    rdx(8'hD4, 32'h0007DF07, "R10 only bits 50:47 writable");
    src(48, 1'b1);
    rdx(8'h94, 32'h0001_6000, "R10 line 48 now rising");
    // R11 read-only writes
    wr(8'hC0, 32'h0);
    wr(8'hCC, 32'h0);
    wr(8'h94, 32'h0);
    rdx(8'hC0, 32'hFFF8FFFF, "R11 sense unchanged");
    rdx(8'hCC, 32'h000000F8, "R11 dual unchanged");
    rd(8'h94, "R11 raw unchanged");
    // R9 edge and clear in the same clock on line 17
    @(negedge clk);
    srcIn[17] = 1'b1;
    wrEn = 1'b1; addr = 8'hD8; wrData = 32'h00020000;
    @(posedge clk);
    #1 wrEn = 1'b0;
    rdx(8'h90, 32'h00020000, "R9 edge beats clear");
    // R5 enable clear drops outputs
    wr(8'hA8, 32'hFFFFFFFF);
    wr(8'hAC, 32'h0007FFFF);
    rdx(8'hA4, 32'h0, "R5 enable cleared");
    check("R5 irq low after clear", 32'(irqOut), 32'h0);
    // Mixed random phase against the model
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      srcIn  = 51'({$urandom, $urandom});
      wrEn   = ($urandom % 3) == 0;
      addr   = (($urandom % 8) == 0) ? 8'(($urandom % 32) * 4)
                                     : 8'h80 + 8'(($urandom % 26) * 4);
      wrData = $urandom;
      rdEn   = 1'b1;
      #1;
      check("R4 R8 R9 random read", rdData, mread(addr));
      rdEn = 1'b0;
      @(posedge clk);
      #1 wrEn = 1'b0;
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule